// File: doc/BRIEF.md
# External Wishbone Bus Gateway

This block connects a simple single-request processor bus to an external Wishbone master port. A request carries an address, write data, byte enables, a read/write flag and a one-cycle valid strobe. The gateway registers it onto the bus and holds the bus cycle open until the device acknowledges, signals an error, or stays silent for too long. It then hands one completion pulse, either acknowledge or error, back to the processor side. For reads, the read data comes with the acknowledge.

Four build-time choices shape the block. The first is classic or pipelined strobe handshaking. The second is whether the returning acknowledge and data pass through a register or go straight through. The third is the byte order seen on the external bus; the processor side is always little-endian. The fourth is a pending-access limit in clock cycles, where zero means no limit. The selected byte order is exposed on a constant status output. Only one access is in flight at a time.

Top module: `ext_wb_gateway`

## Requirements
- R1: A request with `req_valid` high while the bus is idle is sampled at a clock edge. From that edge on, `wb_cyc_o` and `wb_stb_o` are high, with `wb_adr_o` and `wb_we_o` taken from the request. Requests that arrive while `wb_cyc_o` is high are dropped: they start no second bus cycle and produce no second completion.
- R2: With classic handshaking (`PIPELINED`=0), `wb_stb_o` equals `wb_cyc_o` in every cycle.
- R3: With pipelined handshaking (`PIPELINED`=1), `wb_stb_o` is high only in the first cycle of each bus cycle, while `wb_cyc_o` stays high until the access ends.
- R4: While `wb_cyc_o` stays high, `wb_adr_o`, `wb_we_o`, `wb_dat_o` and `wb_sel_o` do not change.
- R5: When `wb_ack_i` or `wb_err_i` is high in a cycle where `wb_cyc_o` is high, `wb_cyc_o` and `wb_stb_o` are low from the next cycle on.
- R6: With `RX_REG`=1, a device acknowledge seen in bus cycle D (counting the first cycle of `wb_cyc_o` as 0) gives a one-cycle `rsp_ack` in cycle D+1. With `RX_REG`=0, `rsp_ack` comes in cycle D itself. `rsp_rdata` carries the read data during `rsp_ack` and is zero in every other cycle.
- R7: A device error ends the access with a single-cycle `rsp_err` at the same latency as an acknowledge, and with no `rsp_ack`. `rsp_ack` and `rsp_err` are never high together.
- R8: With `TIMEOUT`=T>0 and no device response, `wb_cyc_o` stays high for exactly T cycles and then falls. `rsp_err` pulses for one cycle in the first cycle after the fall. A response arriving in the T-th cycle still counts as a normal response.
- R9: With `TIMEOUT`=0, an access waits for a device response however long it takes.
- R10: Byte lane i of `req_wdata` and bit i of `req_be` appear on lane i of the bus when `BIG_ENDIAN`=0, and on lane NB-1-i when `BIG_ENDIAN`=1. Read data is mapped back in the same way.
- R11: `cfg_big_endian` equals the `BIG_ENDIAN` parameter at all times.
- R12: During and straight after reset, `wb_cyc_o`, `wb_stb_o`, `rsp_ack`, `rsp_err` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the processor side |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data, little-endian |
| req_be | input | DATA_W/8 | Byte enables, little-endian |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle error pulse (device error or timeout) |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ack, zero otherwise |
| cfg_big_endian | output | 1 | Constant flag for the external byte order |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADDR_W | Bus address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_sel_o | output | DATA_W/8 | Bus byte select |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_err_i | input | 1 | Bus error |

## Verification
A state register that fails to leave or re-enter idle shows up in the very next cycle. Either `wb_cyc_o` stays high past the response, or a dropped request opens a second bus cycle. Both are visible as a wrong count of bus-active cycles or a second completion pulse. A timeout counter that is off by one moves the fall of `wb_cyc_o` and the `rsp_err` pulse by one cycle, so a silent device run and an acknowledge landing in the last allowed cycle pin both edges. A lane mapping error shows on the first bus cycle as swapped bytes on `wb_dat_o`/`wb_sel_o`, and in the acknowledge cycle on `rsp_rdata`.

// File: rtl/ewg_pkg.sv
`timescale 1ns/1ps
package ewg_pkg;

  typedef enum logic {
    GW_IDLE = 1'b0,
    GW_WAIT = 1'b1
  } gw_state_e;

  // Source lane for destination lane idx; mirrored when rev is set.
  function automatic int unsigned ewg_lane_idx(int unsigned idx, int unsigned lanes, bit rev);
    return rev ? (lanes - 1 - idx) : idx;
  endfunction

endpackage

// File: rtl/ewg_lane_swap.sv
`timescale 1ns/1ps
module ewg_lane_swap #(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter bit REVERSE = 1'b0,
  localparam int TOT_W  = LANES * LANE_W
) (
  input  logic [TOT_W-1:0] din,
  output logic [TOT_W-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SRC = int'(ewg_pkg::ewg_lane_idx(g, LANES, REVERSE));
    assign dout[g*LANE_W +: LANE_W] = din[SRC*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/ewg_timeout.sv
`timescale 1ns/1ps
module ewg_timeout #(
  parameter int LIMIT = 8,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // High in the LIMIT-th consecutive cycle of run
  assign hit = run && (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/ewg_rx_reg.sv
`timescale 1ns/1ps
module ewg_rx_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] dat_o
);

  logic good;
  assign good = active && ack_i && !err_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= good;
      err_o <= active && err_i;
      dat_o <= good ? dat_i : '0;
    end
  end

endmodule

// File: rtl/ext_wb_gateway.sv
`timescale 1ns/1ps
module ext_wb_gateway #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter bit PIPELINED  = 1'b0,
  parameter bit RX_REG     = 1'b1,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter int TIMEOUT    = 255,
  localparam int NB        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NB-1:0]     req_be,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cfg_big_endian,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [NB-1:0]     wb_sel_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  input  logic              wb_err_i
);

  import ewg_pkg::*;

  gw_state_e   state_q;
  logic        accept, bus_done, tmo_hit, tmo_fire, tmo_err_q;
  logic [DATA_W-1:0] wdat_bus, rdat_cpu;
  logic [NB-1:0]     sel_bus;

  assign cfg_big_endian = BIG_ENDIAN;
  assign wb_cyc_o       = (state_q == GW_WAIT);
  assign accept         = req_valid && (state_q == GW_IDLE);
  assign bus_done       = wb_cyc_o && (wb_ack_i || wb_err_i);

  // Lane mapping between processor order and bus order
  ewg_lane_swap #(.LANES(NB), .LANE_W(8), .REVERSE(BIG_ENDIAN)) u_wr_swap (
    .din(req_wdata), .dout(wdat_bus));
  ewg_lane_swap #(.LANES(NB), .LANE_W(1), .REVERSE(BIG_ENDIAN)) u_sel_swap (
    .din(req_be), .dout(sel_bus));
  ewg_lane_swap #(.LANES(NB), .LANE_W(8), .REVERSE(BIG_ENDIAN)) u_rd_swap (
    .din(wb_dat_i), .dout(rdat_cpu));

  // Pending-access limit
  if (TIMEOUT > 0) begin : g_tmo
    ewg_timeout #(.LIMIT(TIMEOUT)) u_tmo (
      .clk(clk), .rst(rst), .run(wb_cyc_o), .hit(tmo_hit));
  end else begin : g_no_tmo
    assign tmo_hit = 1'b0;
  end

  assign tmo_fire = tmo_hit && !bus_done;

  // Outgoing registers and access state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= GW_IDLE;
      wb_stb_o <= 1'b0;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_dat_o <= '0;
      wb_sel_o <= '0;
    end else if (accept) begin
      state_q  <= GW_WAIT;
      wb_stb_o <= 1'b1;
      wb_we_o  <= req_we;
      wb_adr_o <= req_addr;
      wb_dat_o <= wdat_bus;
      wb_sel_o <= sel_bus;
    end else if (state_q == GW_WAIT) begin
      if (bus_done || tmo_hit) begin
        state_q  <= GW_IDLE;
        wb_stb_o <= 1'b0;
      end else if (PIPELINED) begin
        wb_stb_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tmo_err_q <= 1'b0;
    else     tmo_err_q <= tmo_fire;
  end

  // Return path
  if (RX_REG) begin : g_rx_reg
    logic ack_r, err_r;
    ewg_rx_reg #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst(rst), .active(wb_cyc_o),
      .ack_i(wb_ack_i), .err_i(wb_err_i), .dat_i(rdat_cpu),
      .ack_o(ack_r), .err_o(err_r), .dat_o(rsp_rdata));
    assign rsp_ack = ack_r;
    assign rsp_err = err_r || tmo_err_q;
  end else begin : g_rx_comb
    assign rsp_ack   = wb_cyc_o && wb_ack_i && !wb_err_i;
    assign rsp_err   = (wb_cyc_o && wb_err_i) || tmo_err_q;
    assign rsp_rdata = rsp_ack ? rdat_cpu : '0;
  end

endmodule

// File: rtl/ewg_checks.sv
`timescale 1ns/1ps
module ewg_checks #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit PIPELINED = 1'b0,
  parameter int TIMEOUT   = 255,
  localparam int NB       = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic [NB-1:0]     wb_sel_o,
  input logic              wb_ack_i,
  input logic              wb_err_i,
  input logic              rsp_ack,
  input logic              rsp_err
);

  int unsigned cyc_run;

  always_ff @(posedge clk) begin
    if (rst || !wb_cyc_o) cyc_run <= 0;
    else                  cyc_run <= cyc_run + 1;
  end

  // R1
  start_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!wb_cyc_o && req_valid) |=> (wb_cyc_o && wb_stb_o));

  // R2
  classic_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (!PIPELINED && wb_cyc_o) |-> wb_stb_o);

  // R3
  pipe_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (PIPELINED && wb_cyc_o && $past(wb_cyc_o)) |-> !wb_stb_o);

  // R3
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  // R4
  hold_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && $past(wb_cyc_o)) |->
      ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o) && $stable(wb_sel_o)));

  // R5
  end_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && (wb_ack_i || wb_err_i)) |=> !wb_cyc_o);

  // R7
  rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_err));

  // R8
  tmo_window_chk: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o |-> ((TIMEOUT == 0) || (cyc_run < TIMEOUT)));

  // R8
  tmo_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_cyc_o) && !wb_cyc_o && !$past(wb_ack_i || wb_err_i)) |-> rsp_err);

endmodule

bind ext_wb_gateway ewg_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPELINED(PIPELINED), .TIMEOUT(TIMEOUT)
) u_ewg_checks (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
  .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
  .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i),
  .rsp_ack(rsp_ack), .rsp_err(rsp_err)
);

// File: tb/ext_wb_gateway_bench.sv
`timescale 1ns/1ps
module ext_wb_gateway_bench;

  localparam int TMO_A = 8;
  localparam int WIN   = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;

  logic [1:0]  rack, rerr, cfg, wcyc, wstb, wwe, sack, serr;
  logic [31:0] rdat [2];
  logic [31:0] wadr [2];
  logic [31:0] wdo  [2];
  logic [3:0]  wsel [2];
  logic [31:0] sdat [2];

  int tests = 0, fails = 0;

  // Unit 0: classic, registered return, little-endian, timeout 8
  ext_wb_gateway #(.PIPELINED(1'b0), .RX_REG(1'b1), .BIG_ENDIAN(1'b0), .TIMEOUT(TMO_A)) u_ext_wb_gateway (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_ack(rack[0]), .rsp_err(rerr[0]),
    .rsp_rdata(rdat[0]), .cfg_big_endian(cfg[0]), .wb_cyc_o(wcyc[0]), .wb_stb_o(wstb[0]),
    .wb_we_o(wwe[0]), .wb_adr_o(wadr[0]), .wb_dat_o(wdo[0]), .wb_sel_o(wsel[0]),
    .wb_dat_i(sdat[0]), .wb_ack_i(sack[0]), .wb_err_i(serr[0]));

  // Unit 1: pipelined, direct return, big-endian, no timeout
  ext_wb_gateway #(.PIPELINED(1'b1), .RX_REG(1'b0), .BIG_ENDIAN(1'b1), .TIMEOUT(0)) u_ext_wb_gateway_b (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_ack(rack[1]), .rsp_err(rerr[1]),
    .rsp_rdata(rdat[1]), .cfg_big_endian(cfg[1]), .wb_cyc_o(wcyc[1]), .wb_stb_o(wstb[1]),
    .wb_we_o(wwe[1]), .wb_adr_o(wadr[1]), .wb_dat_o(wdo[1]), .wb_sel_o(wsel[1]),
    .wb_dat_i(sdat[1]), .wb_ack_i(sack[1]), .wb_err_i(serr[1]));

  // Device models: mode 0 = ack, 1 = err, 2 = silent
  int sl_dly [2];
  int sl_mode [2];
  int sl_cnt [2];
  bit sl_done [2];

  initial begin
    for (int u = 0; u < 2; u++) begin
      sl_dly[u] = 0; sl_mode[u] = 0; sl_cnt[u] = 0; sl_done[u] = 1'b0;
      sack[u] = 1'b0; serr[u] = 1'b0; sdat[u] = '0;
    end
  end

  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (wcyc[u]) begin
        if (!sl_done[u] && sl_cnt[u] == sl_dly[u] && sl_mode[u] != 2) begin
          sack[u] = (sl_mode[u] == 0);
          serr[u] = (sl_mode[u] == 1);
          sl_done[u] = 1'b1;
        end else begin
          sack[u] = 1'b0;
          serr[u] = 1'b0;
        end
        sl_cnt[u] = sl_cnt[u] + 1;
      end else begin
        sack[u] = 1'b0; serr[u] = 1'b0; sl_cnt[u] = 0; sl_done[u] = 1'b0;
      end
    end
  end

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [3:0] rev4(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic we, input logic [31:0] adr, input logic [31:0] wd,
                            input logic [3:0] be, input int dA, input int mA,
                            input int dB, input int mB, input bit ignore);
    int ack_c [2]; int err_c [2]; int ack_n [2]; int err_n [2];
    int cyc_n [2]; int stb_n [2]; int unstable [2]; int rd_bad [2];
    logic [31:0] rd_got [2];
    logic [31:0] adr0 [2]; logic [31:0] dat0 [2]; logic [3:0] sel0 [2]; logic we0 [2];
    bit first [2];
    logic [31:0] rd_val;
    rd_val = {adr[15:0], ~wd[15:0]};
    @(negedge clk);
    sl_dly[0] = dA; sl_mode[0] = mA; sl_dly[1] = dB; sl_mode[1] = mB;
    sdat[0] = rd_val; sdat[1] = rd_val;
    req_valid = 1'b1; req_we = we; req_addr = adr; req_wdata = wd; req_be = be;
    for (int u = 0; u < 2; u++) begin
      ack_c[u] = -1; err_c[u] = -1; ack_n[u] = 0; err_n[u] = 0; cyc_n[u] = 0;
      stb_n[u] = 0; unstable[u] = 0; rd_bad[u] = 0; rd_got[u] = '0; first[u] = 1'b0;
      adr0[u] = '0; dat0[u] = '0; sel0[u] = '0; we0[u] = 1'b0;
    end
    @(posedge clk);
    for (int c = 0; c < WIN; c++) begin
      #15;
      if (c == 0) begin
        if (ignore) begin req_addr = ~adr; req_wdata = ~wd; req_be = ~be; req_we = ~we; end
        else req_valid = 1'b0;
      end
      if (c == 1) req_valid = 1'b0;
      for (int u = 0; u < 2; u++) begin
        if (rack[u]) begin
          if (ack_c[u] < 0) ack_c[u] = c;
          ack_n[u]++; rd_got[u] = rdat[u];
        end else if (rdat[u] != 32'h0) rd_bad[u]++;
        if (rerr[u]) begin
          if (err_c[u] < 0) err_c[u] = c;
          err_n[u]++;
        end
        if (wstb[u]) stb_n[u]++;
        if (wcyc[u]) begin
          cyc_n[u]++;
          if (c == 0) begin
            first[u] = 1'b1; adr0[u] = wadr[u]; dat0[u] = wdo[u]; sel0[u] = wsel[u]; we0[u] = wwe[u];
          end else if (wadr[u] != adr0[u] || wdo[u] != dat0[u] || wsel[u] != sel0[u] || wwe[u] != we0[u])
            unstable[u]++;
        end
      end
      @(posedge clk);
    end
    for (int u = 0; u < 2; u++) begin
      int d, m, rx, e_cyc, e_lat;
      d = (u == 0) ? dA : dB;
      m = (u == 0) ? mA : mB;
      rx = (u == 0) ? 1 : 0;
      e_cyc = (m == 2) ? TMO_A : d + 1;
      e_lat = (m == 2) ? TMO_A : d + rx;
      // R1 bus cycle opens at the sampling edge with the request fields
      check(first[u] == 1'b1, "R1", "cyc in first cycle", 32'(first[u]), 32'h1);
      check(adr0[u] == adr, "R1", "address", adr0[u], adr);
      check(we0[u] == we, "R1", "write flag", 32'(we0[u]), 32'(we));
      // R10 lane mapping of write data and byte select
      check(dat0[u] == ((u == 0) ? wd : bswap(wd)), "R10", "bus write data", dat0[u],
            (u == 0) ? wd : bswap(wd));
      check(sel0[u] == ((u == 0) ? be : rev4(be)), "R10", "bus byte select", 32'(sel0[u]),
            32'((u == 0) ? be : rev4(be)));
      // R4 stable during the bus cycle
      check(unstable[u] == 0, "R4", "bus fields changed", 32'(unstable[u]), 32'h0);
      // R5 / R8 / R9 bus cycle length; R1 no second cycle from the dropped request
      check(cyc_n[u] == e_cyc, (m == 2) ? "R8" : ((u == 1 && d > TMO_A) ? "R9" : "R5"),
            "cyc cycles", 32'(cyc_n[u]), 32'(e_cyc));
      // R2 / R3 strobe shape
      if (u == 0) check(stb_n[u] == cyc_n[u], "R2", "classic strobe cycles", 32'(stb_n[u]), 32'(cyc_n[u]));
      else        check(stb_n[u] == 1, "R3", "pipelined strobe cycles", 32'(stb_n[u]), 32'h1);
      if (m == 0) begin
        // R6 acknowledge latency and single pulse, read data with ack only
        check(ack_c[u] == e_lat, "R6", "ack latency", 32'(ack_c[u]), 32'(e_lat));
        check(ack_n[u] == 1, ignore ? "R1" : "R6", "ack pulses", 32'(ack_n[u]), 32'h1);
        check(err_n[u] == 0, "R6", "stray error", 32'(err_n[u]), 32'h0);
        check(rd_got[u] == ((u == 0) ? rd_val : bswap(rd_val)), "R10", "read data",
              rd_got[u], (u == 0) ? rd_val : bswap(rd_val));
        check(rd_bad[u] == 0, "R6", "rdata nonzero without ack", 32'(rd_bad[u]), 32'h0);
      end else begin
        // R7 device error, R8 timeout error
        check(err_c[u] == e_lat, (m == 2) ? "R8" : "R7", "error latency", 32'(err_c[u]), 32'(e_lat));
        check(err_n[u] == 1, (m == 2) ? "R8" : "R7", "error pulses", 32'(err_n[u]), 32'h1);
        check(ack_n[u] == 0, "R7", "ack on error", 32'(ack_n[u]), 32'h0);
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #5;
    // R12 outputs quiet in reset; R11 byte-order flag
    for (int u = 0; u < 2; u++) begin
      check({wcyc[u], wstb[u], rack[u], rerr[u]} == 4'h0, "R12", "controls in reset",
            32'({wcyc[u], wstb[u], rack[u], rerr[u]}), 32'h0);
      check(rdat[u] == 32'h0, "R12", "rdata in reset", rdat[u], 32'h0);
    end
    check(cfg[0] == 1'b0, "R11", "little flag", 32'(cfg[0]), 32'h0);
    check(cfg[1] == 1'b1, "R11", "big flag", 32'(cfg[1]), 32'h1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #15;
    check({wcyc, wstb, rack, rerr} == 8'h0, "R12", "controls after reset", 32'({wcyc, wstb, rack, rerr}), 32'h0);

    // R1 R2 R3 R4 R5 R6 R10: sweep direction, byte enables and device delay
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 16; b++)
        run_access(w[0], 32'h1000_0000 + 32'(b * 4), 32'hA1B2_C3D4 ^ 32'(b * 32'h0101_0101),
                   4'(b), b % 3, 0, (b + 1) % 3, 0, 1'b0);
    // R7 device error at several delays
    for (int d = 0; d < 4; d++)
      run_access(1'b0, 32'h2000_0000 + 32'(d), 32'h5566_7788, 4'hF, d, 1, 3 - d, 1, 1'b0);
    // R8 silent device on unit 0; R9 long wait on unit 1
    run_access(1'b1, 32'h3000_0010, 32'hDEAD_BEEF, 4'h6, 0, 2, 30, 0, 1'b0);
    // R8 boundary: response in the last allowed cycle
    run_access(1'b0, 32'h3000_0020, 32'h0BAD_F00D, 4'h9, TMO_A - 1, 0, TMO_A - 1, 0, 1'b0);
    // R1 request held and changed while busy is dropped
    run_access(1'b0, 32'h4000_0040, 32'h1357_9BDF, 4'h3, 2, 0, 2, 0, 1'b1);
    run_access(1'b1, 32'h4000_0080, 32'h2468_ACE0, 4'hC, 5, 0, 4, 0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule